// File: doc/BRIEF.md
# Receiver status-change interrupt controller

This block sits beside a digital audio receiver's decoder and turns changes in the decoded stream state into an active-low interrupt. It samples seven bits of live receiver state each cycle: the non-audio and non-PCM flags, the active-low copyright bit, the pre-emphasis bit, a two-bit recovered rate code and an unlock flag. It also accepts three single-cycle event pulses: invalid frame, channel-status updated and transmission error. Each status field gets a change detector that produces an "update" pulse. With the three events, that gives nine interrupt sources.

Each source can be masked. An unmasked source pulse sets a sticky bit in the pending register, and any pending bit pulls the interrupt line low. A masked source sets nothing and leaves the line alone. The registered copy of the live state still follows the receiver whatever the mask holds. Software reaches the mask register, the pending register and the live state word through a small register port. Reading the pending register clears it.

Top module: `rx_status_irq`

## Requirements
- R1: Address 2 reads the live status word, registered one cycle behind the inputs. Its layout is bit 0 non-audio, bit 1 non-PCM sync seen, bit 2 copyright (active low), bit 3 pre-emphasis, bits 5:4 rate code (00 invalid, 01 96/88.2 kHz, 10 48/44.1 kHz, 11 32 kHz), bit 6 unlock (1 = not locked or no input, 0 = locked). It tracks the inputs regardless of the mask.
- R2: Address 0 is a nine-bit read/write mask register that resets to 0. Bit i masks pending bit i.
- R3: A change in a status field raises a one-cycle update pulse on its source. The sources are bit 0 unlock, bit 4 non-audio, bit 5 non-PCM, bit 6 copyright, bit 7 pre-emphasis, and bit 8 rate (either bit of the code). No update fires in the first cycle after reset. Several fields that change together set all of their bits.
- R4: The invalid, channel-status and transmission-error event pulses set pending bits 1, 2 and 3 respectively.
- R5: A source whose mask bit is 1 sets no pending bit and does not drive the interrupt low. The other sources are unaffected.
- R6: Clearing a mask bit does not set pending bits for events seen while that bit was masked.
- R7: Pending bits are sticky. A read of address 1 returns them and clears them. A source pulse that arrives in the same cycle as that read is kept for the next read.
- R8: `irq_n_o` is high out of reset. It goes low in the cycle after an unmasked source pulse, and returns high in the cycle after the pending register becomes empty.
- R9: Writes to address 1 or 2 change no state.
- R10: Read data appears on `rdata_o` in the cycle after the request. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nonaudio_i | input | 1 | Stream is not audio samples |
| nonpcm_i | input | 1 | Non-PCM sync code seen |
| copy_n_i | input | 1 | Copyright bit, active low |
| preemph_i | input | 1 | Pre-emphasis flag |
| rate_i | input | 2 | Recovered rate code |
| unlock_i | input | 1 | Clock recovery not locked |
| ev_invalid_i | input | 1 | Invalid-frame event pulse |
| ev_csupd_i | input | 1 | Channel-status-updated event pulse |
| ev_txerr_i | input | 1 | Transmission-error event pulse |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 9 | Write data |
| rdata_o | output | 9 | Registered read data |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The bench holds the unlock input high through reset. A design that armed its change detectors too early would raise a spurious unlock interrupt at start-up. One test fires an event pulse in the same cycle as the clearing read; a design that let the clear win would lose that event for good. Another test masks sources, provokes them and then unmasks them. This catches a design that latched masked events, or that replayed them when the mask was lifted. It also catches a live word that froze under the mask. The bench also changes several fields at once and checks for exactly one pulse per change, so a level-triggered detector is exposed.

// File: rtl/rsi_pkg.sv
`timescale 1ns/1ps
package rsi_pkg;
    localparam int NSRC  = 9;
    localparam int SWID  = 7;
    localparam int AW    = 2;

    localparam logic [AW-1:0] A_MASK = 2'd0;
    localparam logic [AW-1:0] A_PEND = 2'd1;
    localparam logic [AW-1:0] A_LIVE = 2'd2;

    localparam int S_UNLOCK = 0;
    localparam int S_INVAL  = 1;
    localparam int S_CSUPD  = 2;
    localparam int S_TXERR  = 3;
    localparam int S_NAUD   = 4;
    localparam int S_NPCM   = 5;
    localparam int S_COPY   = 6;
    localparam int S_PREEMP = 7;
    localparam int S_RATE   = 8;

    typedef struct packed {
        logic       unlock;
        logic [1:0] rate;
        logic       preemph;
        logic       copy_n;
        logic       nonpcm;
        logic       nonaudio;
    } live_t;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/rsi_change_det.sv
`timescale 1ns/1ps
module rsi_change_det #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] chg_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         armed;
    } cd_t;

    cd_t s_d, s_q;

    always_comb begin
        s_d.hold  = cur_i;
        s_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign chg_o[i] = s_q.armed & (cur_i[i] ^ s_q.hold[i]);
    end

    assign hold_o = s_q.hold;
endmodule

// File: rtl/rsi_sticky.sv
`timescale 1ns/1ps
module rsi_sticky #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] mask_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = (flags_q[i] & ~clr_i) | (set_i[i] & ~mask_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/rx_status_irq.sv
`timescale 1ns/1ps
module rx_status_irq
    import rsi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nonaudio_i,
    input  logic            nonpcm_i,
    input  logic            copy_n_i,
    input  logic            preemph_i,
    input  logic [1:0]      rate_i,
    input  logic            unlock_i,
    input  logic            ev_invalid_i,
    input  logic            ev_csupd_i,
    input  logic            ev_txerr_i,
    input  logic            req_i,
    input  logic            we_i,
    input  logic [1:0]      addr_i,
    input  logic [8:0]      wdata_i,
    output logic [8:0]      rdata_o,
    output logic            irq_n_o
);
    live_t           live_in;
    live_t           live_q;
    logic [SWID-1:0] live_hold;
    logic [SWID-1:0] chg;
    logic [NSRC-1:0] src_pulse;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic            rd_pend;
    regs_t           r_d, r_q;

    always_comb begin
        live_in.unlock   = unlock_i;
        live_in.rate     = rate_i;
        live_in.preemph  = preemph_i;
        live_in.copy_n   = copy_n_i;
        live_in.nonpcm   = nonpcm_i;
        live_in.nonaudio = nonaudio_i;
    end

    rsi_change_det #(.W(SWID)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (live_in),
        .hold_o (live_hold),
        .chg_o  (chg)
    );

    assign live_q = live_t'(live_hold);

    always_comb begin
        src_pulse           = '0;
        src_pulse[S_UNLOCK] = chg[6];
        src_pulse[S_INVAL]  = ev_invalid_i;
        src_pulse[S_CSUPD]  = ev_csupd_i;
        src_pulse[S_TXERR]  = ev_txerr_i;
        src_pulse[S_NAUD]   = chg[0];
        src_pulse[S_NPCM]   = chg[1];
        src_pulse[S_COPY]   = chg[2];
        src_pulse[S_PREEMP] = chg[3];
        src_pulse[S_RATE]   = chg[4] | chg[5];
    end

    assign rd_pend = req_i & ~we_i & (addr_i == A_PEND);

    rsi_sticky #(.N(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_pulse),
        .mask_i  (mask_q),
        .clr_i   (rd_pend),
        .flags_o (pend_q)
    );

    always_comb begin
        r_d = r_q;
        if (req_i && we_i && addr_i == A_MASK) begin
            r_d.mask = wdata_i;
        end
        if (req_i && !we_i) begin
            unique case (addr_i)
                A_MASK:  r_d.rdata = r_q.mask;
                A_PEND:  r_d.rdata = pend_q;
                A_LIVE:  r_d.rdata = {{(NSRC-SWID){1'b0}}, live_q};
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mask_q  = r_q.mask;
    assign rdata_o = r_q.rdata;
    assign irq_n_o = ~(|pend_q);
endmodule

// File: rtl/rsi_chk.sv
`timescale 1ns/1ps
module rsi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_invalid_i,
    input logic       ev_txerr_i,
    input logic [6:0] live_hold,
    input logic [6:0] live_in,
    input logic [8:0] mask_q,
    input logic [8:0] pend_q,
    input logic       rd_pend,
    input logic       irq_n_o
);
    // R4
    invalid_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_invalid_i && !mask_q[1]) |=> pend_q[1]);

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_invalid_i && mask_q[1] && !pend_q[1]) |=> !pend_q[1]);

    // R7
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_txerr_i && !mask_q[3]) |=> !irq_n_o);

    // R1
    live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_hold == $past(live_in)));
endmodule

bind rx_status_irq rsi_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_invalid_i (ev_invalid_i),
    .ev_txerr_i   (ev_txerr_i),
    .live_hold    (live_hold),
    .live_in      (live_in),
    .mask_q       (mask_q),
    .pend_q       (pend_q),
    .rd_pend      (rd_pend),
    .irq_n_o      (irq_n_o)
);

// File: tb/rx_status_irq_tb.sv
`timescale 1ns/1ps
module rx_status_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nonaudio_i = 0, nonpcm_i = 0, copy_n_i = 0, preemph_i = 0;
    logic [1:0] rate_i = 2'b00;
    logic       unlock_i = 1'b1;
    logic       ev_invalid_i = 0, ev_csupd_i = 0, ev_txerr_i = 0;
    logic       req_i = 0, we_i = 0;
    logic [1:0] addr_i = 0;
    logic [8:0] wdata_i = 0;
    logic [8:0] rdata_o;
    logic       irq_n_o;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    rx_status_irq u_dut (
        .clk(clk), .rst_n(rst_n),
        .nonaudio_i(nonaudio_i), .nonpcm_i(nonpcm_i), .copy_n_i(copy_n_i),
        .preemph_i(preemph_i), .rate_i(rate_i), .unlock_i(unlock_i),
        .ev_invalid_i(ev_invalid_i), .ev_csupd_i(ev_csupd_i), .ev_txerr_i(ev_txerr_i),
        .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [8:0] d);
        @(negedge clk); req_i = 1; we_i = 0; addr_i = a;
        @(negedge clk); req_i = 0; d = rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] v);
        @(negedge clk); req_i = 1; we_i = 1; addr_i = a; wdata_i = v;
        @(negedge clk); req_i = 0; we_i = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [8:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R8 irq high after reset", irq_n_o, 1);
        chk("R3 no update from reset value", irq_n_o, 1);
        rd(2'd2, d); chk("R1 live word after reset", d, 9'h040);
        rd(2'd0, d); chk("R2 mask reset", d, 9'h000);
        rd(2'd1, d); chk("R7 pending reset", d, 9'h000);
    endtask

    task automatic t_events();
        logic [8:0] d;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ev_invalid_i = (k == 0); ev_csupd_i = (k == 1); ev_txerr_i = (k == 2);
            @(negedge clk);
            ev_invalid_i = 0; ev_csupd_i = 0; ev_txerr_i = 0;
            chk("R8 irq low after event", irq_n_o, 0);
            rd(2'd1, d); chk("R4 event pending bit", d, 9'h002 << k);
            chk("R8 irq high after clear", irq_n_o, 1);
            rd(2'd1, d); chk("R7 cleared by read", d, 9'h000);
        end
    endtask

    task automatic t_fields();
        logic [8:0] d;
        @(negedge clk); rate_i = 2'b10;
        settle();
        chk("R8 irq low on rate change", irq_n_o, 0);
        rd(2'd1, d); chk("R3 rate update bit", d, 9'h100);
        rd(2'd2, d); chk("R1 live rate 48k", d, 9'h060);
        repeat (3) settle();
        rd(2'd1, d); chk("R3 single pulse per change", d, 9'h000);
        @(negedge clk); rate_i = 2'b11; copy_n_i = 1;
        settle();
        rd(2'd1, d); chk("R3 rate+copyright together", d, 9'h140);
        rd(2'd2, d); chk("R1 live rate 32k copyright", d, 9'h074);
        @(negedge clk); unlock_i = 0; preemph_i = 1;
        settle();
        rd(2'd1, d); chk("R3 unlock+preemph", d, 9'h081);
        rd(2'd2, d); chk("R1 live locked preemph", d, 9'h03C);
        @(negedge clk); nonaudio_i = 1; nonpcm_i = 1;
        settle();
        rd(2'd1, d); chk("R3 nonaudio+nonpcm", d, 9'h030);
        rd(2'd2, d); chk("R1 live nonaudio nonpcm", d, 9'h03F);
    endtask

    task automatic t_mask();
        logic [8:0] d;
        wr(2'd0, 9'h1A5); rd(2'd0, d); chk("R2 mask readback", d, 9'h1A5);
        wr(2'd0, 9'h012); rd(2'd0, d); chk("R2 mask readback 2", d, 9'h012);
        @(negedge clk); ev_invalid_i = 1; nonaudio_i = 0;
        @(negedge clk); ev_invalid_i = 0;
        chk("R5 masked irq stays high", irq_n_o, 1);
        rd(2'd1, d); chk("R5 masked no pending", d, 9'h000);
        rd(2'd2, d); chk("R5 live updates while masked", d, 9'h03E);
        @(negedge clk); ev_csupd_i = 1;
        @(negedge clk); ev_csupd_i = 0;
        rd(2'd1, d); chk("R5 unmasked source unaffected", d, 9'h004);
        wr(2'd0, 9'h000);
        chk("R6 unmask no irq", irq_n_o, 1);
        rd(2'd1, d); chk("R6 unmask no retro set", d, 9'h000);
    endtask

    task automatic t_coincide();
        logic [8:0] d;
        @(negedge clk); ev_txerr_i = 1; req_i = 1; we_i = 0; addr_i = 2'd1;
        @(negedge clk); ev_txerr_i = 0; req_i = 0;
        chk("R7 read during set returns prior", rdata_o, 9'h000);
        chk("R7 set survives read (irq)", irq_n_o, 0);
        rd(2'd1, d); chk("R7 set survives read", d, 9'h008);
    endtask

    task automatic t_ignore();
        logic [8:0] d;
        wr(2'd1, 9'h1FF);
        chk("R9 write pending ignored irq", irq_n_o, 1);
        rd(2'd1, d); chk("R9 write pending ignored", d, 9'h000);
        wr(2'd2, 9'h1FF);
        rd(2'd2, d); chk("R9 write live ignored", d, 9'h03E);
        rd(2'd0, d); chk("R9 mask untouched", d, 9'h000);
        rd(2'd3, d); chk("R10 reserved reads zero", d, 9'h000);
        @(negedge clk); req_i = 1; we_i = 0; addr_i = 2'd2;
        #1 chk("R10 data not before edge", rdata_o, 9'h000);
        @(negedge clk); req_i = 0;
        chk("R10 data after edge", rdata_o, 9'h03E);
    endtask

    initial begin
        t_reset();
        t_events();
        t_fields();
        t_mask();
        t_coincide();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule